// File: doc/BRIEF.md
# Receive Special-Condition Interrupt Controller

This block sits beside the receive data path of one serial channel. It sees a strobe each time a character finishes assembly, with that character's end-of-frame, CRC-error and residue indications. It also sees a strobe each time software takes the oldest character out of the receive holding buffer. From these it keeps a count of unread characters and a queue of per-character status. It also keeps a sticky overrun flag that records that a character was lost.

An interrupt request is raised for two kinds of reason. Ordinary data interrupts depend on a two-bit mode. Special conditions are an overrun or an end-of-frame character at the head of the buffer. Special conditions only interrupt when a receive interrupt mode is enabled, and then they do so on every character. The overrun flag survives character reads and is cleared only by an explicit error-reset command. End-of-frame status belongs to one character and goes away when that character is read.

Top module: `rx_special_irq`

## Requirements
- R1: After reset the status word is all zero and `irq` and `irq_special` are low.
- R2: The unread count (status bits [CNT_W-1:0]) rises by one on `char_done`, falls by one on `rd_strobe`, and does not change when both happen together. It never exceeds DEPTH, and a read while the count is zero is ignored.
- R3: A `char_done` with DEPTH characters unread and no read in the same cycle is an overrun. The overrun bit (status MSB) sets, the count stays at DEPTH, and the oldest character's status is dropped so the next one becomes the head.
- R4: The overrun bit stays set through reads and mode changes until `err_reset` is pulsed. A new overrun in the same cycle as `err_reset` leaves it set.
- R5: The head status fields show the oldest unread character, with residue in bits [CNT_W+RES_W-1:CNT_W], CRC error above it and end-of-frame above that. They read zero when the count is zero, and they change to the next character when the head is read.
- R6: `int_mode` 2'b00 and 2'b11 disable interrupts. In a cycle that ends with a disabling mode, `irq` is low after the edge.
- R7: With mode 2'b01 or 2'b10, a set overrun bit or an end-of-frame character at the head raises `irq`. `irq_special` is high exactly while `irq` is high and such a condition is present.
- R8: In mode 2'b10 (every character), `irq` is raised whenever the unread count is non-zero.
- R9: In mode 2'b01 (first character only), a data interrupt is raised only for the first character completed after the mode is entered. Later characters interrupt only through a special condition.
- R10: `irq` rises on the clock edge after its cause is registered and holds until `int_ack`. After an acknowledge it is low for one cycle, and it returns on the next edge if a cause is still present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| int_mode | input | 2 | Receive interrupt mode: 00 off, 01 first character, 10 every character, 11 off |
| char_done | input | 1 | A character has finished assembly this cycle |
| char_eof | input | 1 | The finishing character closes a frame |
| char_crc_err | input | 1 | CRC check of the finishing character failed |
| char_residue | input | RES_W | Residue code of the finishing character |
| rd_strobe | input | 1 | Software reads the oldest buffered character |
| err_reset | input | 1 | Error-reset command, clears the overrun bit |
| int_ack | input | 1 | Interrupt acknowledge |
| status_word | output | CNT_W+RES_W+3 | {overrun, head eof, head crc error, head residue, unread count} |
| irq | output | 1 | Interrupt request |
| irq_special | output | 1 | Request is due to a special receive condition |

## Verification
The bench builds the block with DEPTH=2 and RES_W=2. At that size the buffer fills after two characters, so overrun, head dropping and the end-of-frame queue order are reached within a few cycles. All four mode codes, including the reserved one, are walked through in every phase. A scripted run covers each corner first. A long pseudo-random sweep then compares every output, every cycle, against an arithmetic model of the requirements.

// File: rtl/rxsi_pkg.sv
package rxsi_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'd0,
      MODE_FIRST = 2'd1,
      MODE_EVERY = 2'd2,
      MODE_RSVD  = 2'd3
   } rx_irq_mode_e;

   function automatic logic mode_enabled(input logic [1:0] m);
      return (m == MODE_FIRST) || (m == MODE_EVERY);
   endfunction

endpackage

// File: rtl/rxsi_occupancy.sv
module rxsi_occupancy #(
   parameter int DEPTH = 2,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             char_done,
   input  logic             rd_req,
   output logic [CNT_W-1:0] cnt,
   output logic             pop_read,
   output logic             overrun
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic full;

   assign full     = (cnt == FULL_CNT);
   assign pop_read = rd_req && (cnt != '0);
   assign overrun  = char_done && full && !pop_read;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         unique case ({char_done, pop_read})
            2'b10:   if (!full) cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/rxsi_status_queue.sv
module rxsi_status_queue #(
   parameter int DEPTH = 2,
   parameter int RES_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             in_eof,
   input  logic             in_crc,
   input  logic [RES_W-1:0] in_res,
   output logic             head_eof,
   output logic             head_crc,
   output logic [RES_W-1:0] head_res
);
   localparam int EW = RES_W + 2;

   logic [EW-1:0] in_ent;
   logic [EW-1:0] head_ent;

   assign in_ent = {in_eof, in_crc, in_res};
   assign {head_eof, head_crc, head_res} = head_ent;

   generate
      if (DEPTH == 1) begin : g_single
         logic [EW-1:0] ent_q;
         always_ff @(posedge clk) begin
            if (!rst_n)     ent_q <= '0;
            else if (push)  ent_q <= in_ent;
            else if (pop)   ent_q <= '0;
         end
         assign head_ent = ent_q;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

         logic [EW-1:0] mem_q [DEPTH];
         logic [PW-1:0] wp_q, rp_q;

         function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
            return (p == LAST) ? '0 : p + 1'b1;
         endfunction

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wp_q <= '0;
               rp_q <= '0;
               for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else begin
               if (push) begin
                  mem_q[wp_q] <= in_ent;
                  wp_q        <= step(wp_q);
               end
               if (pop) rp_q <= step(rp_q);
            end
         end
         assign head_ent = mem_q[rp_q];
      end
   endgenerate
endmodule

// File: rtl/rxsi_irq_ctrl.sv
module rxsi_irq_ctrl
   import rxsi_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       char_done,
   input  logic       overrun,
   input  logic       err_reset,
   input  logic       ack,
   input  logic       avail,
   input  logic       head_eof,
   output logic       ovr_flag,
   output logic       irq,
   output logic       irq_special
);
   logic [1:0] mode_q;
   logic       armed_q, first_pend_q;
   logic       en, entering, first_hit, spec_cond, data_cond;

   assign en        = mode_enabled(mode);
   assign entering  = (mode == MODE_FIRST) && (mode_q != MODE_FIRST);
   assign first_hit = char_done && (mode == MODE_FIRST) && (armed_q || entering);
   assign spec_cond = ovr_flag || (avail && head_eof);
   assign data_cond = ((mode == MODE_EVERY) && avail) ||
                      ((mode == MODE_FIRST) && first_pend_q);
   assign irq_special = irq && spec_cond;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q       <= MODE_OFF;
         armed_q      <= 1'b0;
         first_pend_q <= 1'b0;
         ovr_flag     <= 1'b0;
         irq          <= 1'b0;
      end else begin
         mode_q <= mode;

         if (overrun)        ovr_flag <= 1'b1;
         else if (err_reset) ovr_flag <= 1'b0;

         if (first_hit)     armed_q <= 1'b0;
         else if (entering) armed_q <= 1'b1;

         if (first_hit)                          first_pend_q <= 1'b1;
         else if (ack || (mode != MODE_FIRST))   first_pend_q <= 1'b0;

         if (ack) irq <= 1'b0;
         else     irq <= en && (irq || spec_cond || data_cond);
      end
   end
endmodule

// File: rtl/rx_special_irq.sv
module rx_special_irq #(
   parameter int DEPTH = 2,
   parameter int RES_W = 3,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int SW_W  = CNT_W + RES_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       int_mode,
   input  logic             char_done,
   input  logic             char_eof,
   input  logic             char_crc_err,
   input  logic [RES_W-1:0] char_residue,
   input  logic             rd_strobe,
   input  logic             err_reset,
   input  logic             int_ack,
   output logic [SW_W-1:0]  status_word,
   output logic             irq,
   output logic             irq_special
);
   initial begin
      assert (DEPTH >= 1) else $error("rx_special_irq: DEPTH must be at least 1");
      assert (RES_W >= 1) else $error("rx_special_irq: RES_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic             pop_read, overrun, avail, ovr_flag;
   logic             q_eof, q_crc;
   logic [RES_W-1:0] q_res;

   rxsi_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
      .clk      (clk),
      .rst_n    (rst_n),
      .char_done(char_done),
      .rd_req   (rd_strobe),
      .cnt      (cnt),
      .pop_read (pop_read),
      .overrun  (overrun)
   );

   rxsi_status_queue #(.DEPTH(DEPTH), .RES_W(RES_W)) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (char_done),
      .pop     (pop_read || overrun),
      .in_eof  (char_eof),
      .in_crc  (char_crc_err),
      .in_res  (char_residue),
      .head_eof(q_eof),
      .head_crc(q_crc),
      .head_res(q_res)
   );

   assign avail = (cnt != '0);

   rxsi_irq_ctrl u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (int_mode),
      .char_done  (char_done),
      .overrun    (overrun),
      .err_reset  (err_reset),
      .ack        (int_ack),
      .avail      (avail),
      .head_eof   (q_eof),
      .ovr_flag   (ovr_flag),
      .irq        (irq),
      .irq_special(irq_special)
   );

   assign status_word = {ovr_flag,
                         avail && q_eof,
                         avail && q_crc,
                         avail ? q_res : {RES_W{1'b0}},
                         cnt};
endmodule

// File: rtl/rx_special_irq_chk.sv
module rx_special_irq_chk #(
   parameter int DEPTH = 2,
   parameter int RES_W = 3,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int SW_W  = CNT_W + RES_W + 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       int_mode,
   input logic             char_done,
   input logic             rd_strobe,
   input logic             err_reset,
   input logic             int_ack,
   input logic [SW_W-1:0]  status_word,
   input logic             irq,
   input logic             irq_special
);
   logic [CNT_W-1:0] c_cnt;
   logic             c_ovr, c_eof, c_crc;
   logic [RES_W-1:0] c_res;
   logic             c_en;

   assign {c_ovr, c_eof, c_crc, c_res, c_cnt} = status_word;
   assign c_en = (int_mode == 2'd1) || (int_mode == 2'd2);

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      c_cnt <= CNT_W'(DEPTH));

   p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (char_done && c_cnt == CNT_W'(DEPTH) && !rd_strobe) |=> (c_ovr && c_cnt == CNT_W'(DEPTH)));

   p_overrun_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (c_ovr && !err_reset) |=> c_ovr);

   p_empty_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (c_cnt == '0) |-> (!c_eof && !c_crc && c_res == '0));

   p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !c_en |=> !irq);

   p_special_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_special |-> irq);

   p_ack_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack |=> !irq);

   p_irq_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !int_ack && c_en) |=> irq);
endmodule

bind rx_special_irq rx_special_irq_chk #(.DEPTH(DEPTH), .RES_W(RES_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .int_mode   (int_mode),
   .char_done  (char_done),
   .rd_strobe  (rd_strobe),
   .err_reset  (err_reset),
   .int_ack    (int_ack),
   .status_word(status_word),
   .irq        (irq),
   .irq_special(irq_special)
);

// File: tb/rx_special_irq_bench.sv
`timescale 1ns/1ps
module rx_special_irq_bench;
   localparam int DEPTH = 2;
   localparam int RES_W = 2;
   localparam int CNT_W = 2;
   localparam int SW_W  = CNT_W + RES_W + 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       int_mode = 2'd0;
   logic             char_done = 1'b0, char_eof = 1'b0, char_crc_err = 1'b0;
   logic [RES_W-1:0] char_residue = '0;
   logic             rd_strobe = 1'b0, err_reset = 1'b0, int_ack = 1'b0;
   logic [SW_W-1:0]  status_word;
   logic             irq, irq_special;

   always #2 clk = ~clk;

   rx_special_irq #(.DEPTH(DEPTH), .RES_W(RES_W)) u_rx_special_irq (
      .clk(clk), .rst_n(rst_n), .int_mode(int_mode), .char_done(char_done),
      .char_eof(char_eof), .char_crc_err(char_crc_err), .char_residue(char_residue),
      .rd_strobe(rd_strobe), .err_reset(err_reset), .int_ack(int_ack),
      .status_word(status_word), .irq(irq), .irq_special(irq_special)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;
   bit cmp_on = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // status field views
   wire [1:0] s_cnt = status_word[1:0];
   wire [1:0] s_res = status_word[3:2];
   wire       s_crc = status_word[4];
   wire       s_eof = status_word[5];
   wire       s_ovr = status_word[6];

   // reference model, built from the requirements
   int   m_cnt;
   bit   m_eof [2];
   bit   m_crc [2];
   int   m_res [2];
   bit   m_ovr, m_irq, m_armed, m_fp;
   int   m_modeq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_ovr = 0; m_irq = 0; m_armed = 0; m_fp = 0; m_modeq = 0;
         for (int i = 0; i < 2; i++) begin m_eof[i] = 0; m_crc[i] = 0; m_res[i] = 0; end
      end else begin
         bit avail, pop_rd, ovr_ev, spec, data, en, entering, hit;
         int md;
         md       = int_mode;
         avail    = (m_cnt != 0);
         pop_rd   = rd_strobe && avail;
         ovr_ev   = char_done && (m_cnt == DEPTH) && !pop_rd;
         spec     = m_ovr || (avail && m_eof[0]);
         data     = (md == 2 && avail) || (md == 1 && m_fp);
         en       = (md == 1) || (md == 2);
         entering = (md == 1) && (m_modeq != 1);
         hit      = char_done && (md == 1) && (m_armed || entering);
         m_irq    = int_ack ? 1'b0 : (en && (m_irq || spec || data));
         if (hit) m_fp = 1; else if (int_ack || md != 1) m_fp = 0;
         if (hit) m_armed = 0; else if (entering) m_armed = 1;
         m_modeq = md;
         if (ovr_ev) m_ovr = 1; else if (err_reset) m_ovr = 0;
         if (pop_rd || ovr_ev) begin
            m_eof[0] = m_eof[1]; m_crc[0] = m_crc[1]; m_res[0] = m_res[1];
            m_eof[1] = 0; m_crc[1] = 0; m_res[1] = 0;
            m_cnt = m_cnt - 1;
         end
         if (char_done) begin
            m_eof[m_cnt] = char_eof; m_crc[m_cnt] = char_crc_err; m_res[m_cnt] = int'(char_residue);
            m_cnt = m_cnt + 1;
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_on && !finished) begin
         bit hv, x_spec;
         hv = (m_cnt != 0);
         x_spec = m_irq && (m_ovr || (hv && m_eof[0]));
         check(s_cnt == m_cnt, "R2 model count", s_cnt, m_cnt);
         check(s_ovr == m_ovr, "R4 model overrun", s_ovr, m_ovr);
         check(s_eof == (hv && m_eof[0]) && s_crc == (hv && m_crc[0]) &&
               s_res == (hv ? m_res[0] : 0), "R5 model head",
               {s_eof, s_crc, s_res}, {hv && m_eof[0], hv && m_crc[0], 2'(hv ? m_res[0] : 0)});
         check(irq == m_irq, "R10 model irq", irq, m_irq);
         check(irq_special == x_spec, "R7 model irq_special", irq_special, x_spec);
      end
   end

   // one clock: inputs set now (at a falling edge), returns at the next falling edge
   task automatic cyc(input bit d, input bit e, input bit c, input int r,
                      input bit rd, input bit ak, input bit er);
      char_done = d; char_eof = e; char_crc_err = c; char_residue = 2'(r);
      rd_strobe = rd; int_ack = ak; err_reset = er;
      @(negedge clk);
      char_done = 0; char_eof = 0; char_crc_err = 0; char_residue = '0;
      rd_strobe = 0; int_ack = 0; err_reset = 0;
   endtask

   initial begin
      #(4 * 100000);
      if (!finished) begin
         failures++; checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      check(status_word == '0, "R1 status after reset", status_word, 0);
      check(irq == 0 && irq_special == 0, "R1 irq after reset", irq, 0);
      cmp_on = 1;

      int_mode = 2'd2;
      cyc(0,0,0,0,0,0,0);
      cyc(1,0,0,1,0,0,0);
      check(s_cnt == 1, "R2 count after one char", s_cnt, 1);
      cyc(0,0,0,0,0,0,0);
      check(irq == 1 && irq_special == 0, "R8 every-char irq", irq, 1);
      cyc(1,1,1,2,0,0,0);
      cyc(1,0,0,3,0,0,0);
      check(s_cnt == 2 && s_ovr == 1, "R3 overrun sets, count holds", {s_ovr, s_cnt}, 6);
      check(s_res == 2 && s_eof == 1 && s_crc == 1, "R3 oldest dropped", {s_eof, s_crc, s_res}, 14);
      cyc(0,0,0,0,1,0,0);
      check(s_ovr == 1 && s_cnt == 1, "R4 overrun survives read", {s_ovr, s_cnt}, 5);
      cyc(0,0,0,0,0,0,1);
      check(s_ovr == 0, "R4 err_reset clears", s_ovr, 0);
      check(s_res == 3 && s_eof == 0, "R5 next head", {s_eof, s_res}, 3);
      cyc(0,0,0,0,1,0,0);
      check(s_cnt == 0 && s_eof == 0 && s_res == 0, "R5 empty head zero", status_word, 0);
      cyc(0,0,0,0,1,0,0);
      check(s_cnt == 0, "R2 read when empty ignored", s_cnt, 0);
      cyc(0,0,0,0,0,1,0);
      check(irq == 0, "R10 ack drops irq", irq, 0);
      cyc(0,0,0,0,0,0,0);
      check(irq == 0, "R10 no cause stays low", irq, 0);
      cyc(1,0,0,0,0,0,0);
      cyc(0,0,0,0,0,0,0);
      cyc(0,0,0,0,0,1,0);
      check(irq == 0, "R10 low after ack", irq, 0);
      cyc(0,0,0,0,0,0,0);
      check(irq == 1, "R10 reasserts while cause persists", irq, 1);
      int_mode = 2'd3;
      cyc(0,0,0,0,0,0,0);
      check(irq == 0, "R6 reserved mode disables", irq, 0);
      cyc(0,0,0,0,1,0,0);
      int_mode = 2'd1;
      cyc(0,0,0,0,0,0,0);
      cyc(1,0,0,0,0,0,0);
      cyc(0,0,0,0,0,0,0);
      check(irq == 1, "R9 first char interrupts", irq, 1);
      cyc(0,0,0,0,1,1,0);
      cyc(1,0,0,1,0,0,0);
      cyc(0,0,0,0,0,0,0);
      cyc(0,0,0,0,0,0,0);
      check(irq == 0, "R9 later char no data irq", irq, 0);
      cyc(1,1,0,2,0,0,0);
      cyc(0,0,0,0,1,0,0);
      cyc(0,0,0,0,0,0,0);
      check(irq == 1 && irq_special == 1, "R7 eof at head raises special", {irq, irq_special}, 3);
      int_mode = 2'd0;
      cyc(0,0,0,0,0,0,0);
      check(irq == 0, "R6 off mode disables", irq, 0);

      // pseudo-random sweep, model compared each cycle
      lfsr = 16'hACE1;
      for (int ph = 0; ph < 16; ph++) begin
         int_mode = 2'(ph);
         for (int k = 0; k < 200; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0], lfsr[1], lfsr[2], int'(lfsr[4:3]), lfsr[5] & lfsr[6],
                lfsr[7] & lfsr[8] & lfsr[9], lfsr[10] & lfsr[11] & lfsr[12] & lfsr[13]);
         end
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule